// File: doc/BRIEF.md
# Strobe-Latched Serial Shift Register

This block takes a slow serial stream (data plus its own shift clock) and turns it into a parallel byte. A fast system clock oversamples the shift clock, data and strobe through synchronisers. Rising and falling edges of the shift clock are found inside the block. On every rising shift edge a new bit enters the first stage and the rest of the register moves one place toward the last stage. A storage latch sits between the register and the parallel outputs. While the strobe is high the latch is transparent. While the strobe is low it holds its value.

The parallel outputs come out as a value plus a per-bit drive-enable, so a pad ring can build the tri-state buffers. When output enable is low, every enable bit is cleared, but shifting goes on. Two cascade bits carry the last stage on to a following device. One updates on the rising shift edge. The other updates only on the falling edge, which gives the next device in a chain half a shift period of extra hold time. Chaining instances through the falling-edge bit makes one longer register.

Top module: `strobe_shift_reg`

## Requirements
- R1: On each rising shift edge, stage 1 (`par_val[0]` side) takes the sampled data bit and each stage n takes the old value of stage n-1. After eight rising edges the first bit sent is in the last stage (`par_val[WIDTH-1]`).
- R2: While the synchronised strobe is high, the latch follows the register contents. The new contents appear on `par_val` in the same cycle as a rising-edge shift, and raising the strobe without shifting also loads the current contents.
- R3: While the strobe is low, `par_val` keeps its latched value whatever shifting takes place.
- R4: When `oe_in` is low, all bits of `par_drv_en` are 0, while shifting and both cascade outputs go on working. When `oe_in` is high, all bits are 1.
- R5: `cas_rise` updates on each rising shift edge to the value the last stage held before that edge. The first bit sent after reset appears there at the 9th rising edge.
- R6: `cas_fall` changes only on a falling shift edge, where it copies the last stage. The first bit sent appears there at the falling edge after the 8th rising edge.
- R7: A falling shift edge changes neither the shift stages, the parallel value while the strobe is low or steady, nor `cas_rise`.
- R8: A synchronous active-high `rst` clears the shift stages, the latch and both cascade outputs to 0.
- R9: A level change on `sclk_in` that is sampled at system edge k is acted on at system edge k+2, through two synchronising flops.
- R10: With two instances chained through `cas_fall`, sending 16 bits MSB first and then pulsing the strobe leaves the upper byte in the second instance and the lower byte in the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Asynchronous shift clock |
| sdata_in | input | 1 | Asynchronous serial data |
| strobe_in | input | 1 | Asynchronous latch transparency control |
| oe_in | input | 1 | Output enable for the parallel pins |
| par_val | output | WIDTH | Latched parallel value |
| par_drv_en | output | WIDTH | Per-bit drive enable for the parallel pins |
| cas_rise | output | 1 | Cascade bit updated on rising shift edges |
| cas_fall | output | 1 | Cascade bit updated on falling shift edges |

## Verification
The bench targets when things happen. It checks the two-cycle synchroniser latency exactly: a design with one flop too few or too many shows the parallel value one cycle early or late. It checks that the first bit reaches the rising-edge cascade bit only at the 9th edge, which catches a design that forwards the new last stage instead of the old one. It checks that the falling-edge cascade bit moves only on falling edges, which catches a design that clocks it on the wrong edge. It also holds the strobe low while shifting, which catches a latch that leaks. Finally it drops output enable during shifting, so a design that freezes the register together with the pins loses the byte. A two-device chain carrying 16 bits shows whether the hold-time bit really feeds the next stage without a slipped or doubled bit.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  // Bundle of asynchronous serial controls that share one synchroniser
  typedef struct packed {
    logic sclk;
    logic data;
    logic strobe;
  } serial_ctl_t;

  localparam serial_ctl_t CTL_IDLE = '{sclk: 1'b0, data: 1'b0, strobe: 1'b0};
endpackage

// File: rtl/sreg_sync_edge.sv
module sreg_sync_edge
  import sreg_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  serial_ctl_t raw_ctl,
  output serial_ctl_t sync_ctl,
  output logic        rise_evt,
  output logic        fall_evt
);
  serial_ctl_t pipe [STAGES];
  logic        sclk_prev;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= CTL_IDLE;
          else     pipe[0] <= raw_ctl;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[gi] <= CTL_IDLE;
          else     pipe[gi] <= pipe[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= pipe[STAGES-1].sclk;
  end

  assign sync_ctl = pipe[STAGES-1];
  assign rise_evt = sync_ctl.sclk & ~sclk_prev;
  assign fall_evt = ~sync_ctl.sclk & sclk_prev;
endmodule

// File: rtl/sreg_shift_core.sv
module sreg_shift_core #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_evt,
  input  logic             fall_evt,
  input  logic             data_bit,
  output logic [WIDTH-1:0] stage_q,
  output logic [WIDTH-1:0] stage_nxt,
  output logic             cas_rise,
  output logic             cas_fall
);
  localparam int LAST = WIDTH - 1;

  function automatic logic [WIDTH-1:0] push_bit(input logic [WIDTH-1:0] cur,
                                                input logic b);
    return {cur[LAST-1:0], b};
  endfunction

  always_comb begin
    stage_nxt = rise_evt ? push_bit(stage_q, data_bit) : stage_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q  <= '0;
      cas_rise <= 1'b0;
      cas_fall <= 1'b0;
    end else begin
      stage_q <= stage_nxt;
      if (rise_evt) cas_rise <= stage_q[LAST];
      if (fall_evt) cas_fall <= stage_q[LAST];
    end
  end
endmodule

// File: rtl/sreg_out_latch.sv
module sreg_out_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic             oe,
  input  logic [WIDTH-1:0] stage_nxt,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] drv_en
);
  always_ff @(posedge clk) begin
    if (rst)         latch_q <= '0;
    else if (strobe) latch_q <= stage_nxt;
  end

  assign drv_en = {WIDTH{oe}};
endmodule

// File: rtl/strobe_shift_reg.sv
module strobe_shift_reg
  import sreg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_in,
  input  logic             sdata_in,
  input  logic             strobe_in,
  input  logic             oe_in,
  output logic [WIDTH-1:0] par_val,
  output logic [WIDTH-1:0] par_drv_en,
  output logic             cas_rise,
  output logic             cas_fall
);
  serial_ctl_t      raw_ctl;
  serial_ctl_t      sync_ctl;
  logic             rise_evt;
  logic             fall_evt;
  logic             data_s;
  logic             strobe_s;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;

  assign raw_ctl = '{sclk: sclk_in, data: sdata_in, strobe: strobe_in};

  sreg_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .raw_ctl  (raw_ctl),
    .sync_ctl (sync_ctl),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign data_s   = sync_ctl.data;
  assign strobe_s = sync_ctl.strobe;

  sreg_shift_core #(.WIDTH(WIDTH)) core_i (
    .clk       (clk),
    .rst       (rst),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .data_bit  (data_s),
    .stage_q   (stage_q),
    .stage_nxt (stage_nxt),
    .cas_rise  (cas_rise),
    .cas_fall  (cas_fall)
  );

  sreg_out_latch #(.WIDTH(WIDTH)) latch_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe_s),
    .oe        (oe_in),
    .stage_nxt (stage_nxt),
    .latch_q   (par_val),
    .drv_en    (par_drv_en)
  );
endmodule

// File: rtl/sreg_chk.sv
module sreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rise_evt,
  input logic             fall_evt,
  input logic             data_s,
  input logic             strobe_s,
  input logic [WIDTH-1:0] stage_q,
  input logic [WIDTH-1:0] par_val,
  input logic             cas_rise,
  input logic             cas_fall
);
  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> (stage_q[0] == $past(data_s)) &&
                 (stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])));

  // R2
  transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe_s && rise_evt) |=> (par_val == stage_q));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_s |=> $stable(par_val));

  // R5
  rise_cascade_chk: assert property (@(posedge clk) disable iff (rst)
    rise_evt |=> (cas_rise == $past(stage_q[WIDTH-1])));

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    !fall_evt |=> $stable(cas_fall));

  // R7
  fall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fall_evt |=> $stable(stage_q) && $stable(cas_rise));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stage_q == '0) && (par_val == '0) && !cas_rise && !cas_fall);
endmodule

bind strobe_shift_reg sreg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rise_evt (rise_evt),
  .fall_evt (fall_evt),
  .data_s   (data_s),
  .strobe_s (strobe_s),
  .stage_q  (stage_q),
  .par_val  (par_val),
  .cas_rise (cas_rise),
  .cas_fall (cas_fall)
);

// File: tb/strobe_shift_reg_tb_top.sv
`timescale 1ns/1ps
module strobe_shift_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, stb = 1'b0, oe = 1'b1;
  logic [7:0] a_par, a_en, b_par, b_en;
  logic a_rise, a_fall, b_rise, b_fall;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobe_shift_reg dut_i (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(sdat), .strobe_in(stb),
    .oe_in(oe), .par_val(a_par), .par_drv_en(a_en), .cas_rise(a_rise),
    .cas_fall(a_fall));

  strobe_shift_reg dut_b (
    .clk(clk), .rst(rst), .sclk_in(sclk), .sdata_in(a_fall), .strobe_in(stb),
    .oe_in(oe), .par_val(b_par), .par_drv_en(b_en), .cas_rise(b_rise),
    .cas_fall(b_fall));

  // Behavioural reference for both devices: input history, two-cycle delay
  logic [7:0] m_stage [2];
  logic [7:0] m_latch [2];
  logic       m_rise  [2];
  logic       m_fall  [2];
  logic [2:0] hc [2];
  logic [2:0] hd [2];
  logic [2:0] hs [2];

  always @(posedge clk) begin
    logic chain_in;
    chain_in = m_fall[0];
    for (int dv = 0; dv < 2; dv++) begin
      if (rst) begin
        m_stage[dv] = 8'h00; m_latch[dv] = 8'h00;
        m_rise[dv] = 1'b0;   m_fall[dv] = 1'b0;
        hc[dv] = 3'b000; hd[dv] = 3'b000; hs[dv] = 3'b000;
      end else begin
        logic up, dn;
        up = hc[dv][1] && !hc[dv][2];
        dn = !hc[dv][1] && hc[dv][2];
        if (dn) m_fall[dv] = m_stage[dv][7];
        if (up) begin
          m_rise[dv]  = m_stage[dv][7];
          m_stage[dv] = (m_stage[dv] << 1) | {7'b0, hd[dv][1]};
        end
        if (hs[dv][1]) m_latch[dv] = m_stage[dv];
        hc[dv] = {hc[dv][1:0], sclk};
        hd[dv] = {hd[dv][1:0], (dv == 0) ? sdat : chain_in};
        hs[dv] = {hs[dv][1:0], stb};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!done) begin
      chk("R2/R3 par_val dev0", {24'b0, a_par}, {24'b0, m_latch[0]});
      chk("R2/R3 par_val dev1", {24'b0, b_par}, {24'b0, m_latch[1]});
      chk("R5 cas_rise", {30'b0, b_rise, a_rise}, {30'b0, m_rise[1], m_rise[0]});
      chk("R6 cas_fall", {30'b0, b_fall, a_fall}, {30'b0, m_fall[1], m_fall[0]});
      chk("R4 drive enable", {16'b0, b_en, a_en}, {16'b0, {16{oe}}});
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic rise_half(input logic d);
    sdat = d; wait_n(3); sclk = 1'b1; wait_n(6);
  endtask
  task automatic fall_half();
    sclk = 1'b0; wait_n(6);
  endtask
  task automatic send_bit(input logic d);
    rise_half(d); fall_half();
  endtask
  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] p_hold;
    logic       r_hold;
    wait_n(4);
    rst = 1'b0;
    wait_n(2);
    // R8: reset state
    chk("R8 reset par", {24'b0, a_par}, 32'h0);
    chk("R8 reset cascades", {30'b0, a_rise, a_fall}, 32'h0);

    // R9: latency of exactly two system edges
    stb = 1'b1; sdat = 1'b1; wait_n(3);
    sclk = 1'b1;
    wait_n(2);
    chk("R9 not yet shifted at k+1", {24'b0, a_par}, 32'h00);
    wait_n(1);
    chk("R9 shifted at k+2", {24'b0, a_par}, 32'h01);
    wait_n(3);
    fall_half();

    // R1/R5/R6/R7: push the first bit through to the end
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    rise_half(1'b0);
    chk("R1 first bit in last stage", {24'b0, a_par}, 32'h80);
    chk("R5 cas_rise still 0 at 8th edge", {31'b0, a_rise}, 32'h0);
    chk("R6 cas_fall waits for falling edge", {31'b0, a_fall}, 32'h0);
    fall_half();
    chk("R6 cas_fall after 8th fall", {31'b0, a_fall}, 32'h1);
    rise_half(1'b0);
    chk("R5 first bit at 9th rising edge", {31'b0, a_rise}, 32'h1);
    p_hold = a_par; r_hold = a_rise;
    fall_half();
    chk("R7 par unchanged on fall", {24'b0, a_par}, {24'b0, p_hold});
    chk("R7 cas_rise unchanged on fall", {31'b0, a_rise}, {31'b0, r_hold});

    // R2/R3: transparent, hold, then reload on strobe raise
    send_byte(8'hA5);
    chk("R2 transparent byte", {24'b0, a_par}, 32'hA5);
    stb = 1'b0; wait_n(4);
    send_byte(8'h3C);
    chk("R3 held while strobe low", {24'b0, a_par}, 32'hA5);
    stb = 1'b1; wait_n(5);
    chk("R2 strobe raise loads contents", {24'b0, a_par}, 32'h3C);

    // R4: pins released, shifting continues
    oe = 1'b0; wait_n(1);
    chk("R4 drive enable cleared", {24'b0, a_en}, 32'h00);
    send_byte(8'h5A);
    chk("R4 still cleared after shifting", {24'b0, a_en}, 32'h00);
    oe = 1'b1; wait_n(1);
    chk("R4 drive enable set", {24'b0, a_en}, 32'hFF);
    chk("R4 byte shifted while disabled", {24'b0, a_par}, 32'h5A);

    // R10: two-device chain, 16 bits then a strobe pulse
    stb = 1'b0; wait_n(4);
    send_byte(8'hC3);
    send_byte(8'h96);
    stb = 1'b1; wait_n(5);
    stb = 1'b0; wait_n(5);
    chk("R10 upper byte in second device", {24'b0, b_par}, 32'hC3);
    chk("R10 lower byte in first device", {24'b0, a_par}, 32'h96);

    done = 1;
    wait_n(1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule